// File: doc/BRIEF.md
# LPC Cycle Window Decoder

This block sits between a host request port and an internal on-chip bus. A host names one of three LPC address spaces (port I/O, memory, or firmware), a 32-bit address inside that space, a byte count and a direction. The block decides in the same cycle whether the request is legal for that space. If it is legal, it produces the internal bus address by adding the fixed window base of the space and raises a start strobe. If it is not legal, it answers with a parameter error and starts nothing.

Firmware space is reached through 256 MiB segments. The block keeps a 4-bit segment-select register that tracks the segment of the last accepted firmware access. It also keeps a read-size register whose coded size field tracks the byte count of the last accepted firmware read. Each register is rewritten only when the new value differs from the one it holds, and the block raises a one-cycle write strobe when it does so. After reset both registers count as unknown, so the first accepted firmware access always writes them.

Top module: `lpc_window_xlate`

## Requirements
- R1: A port I/O request (space code 0) is accepted only when its size is 1 and its end address (address plus size) is at most 0x10000. Any other port I/O request is rejected.
- R2: A memory request (space code 1) is accepted only when its size is 1 and its end address is at most 0x10000000. Any other memory request is rejected.
- R3: A firmware request (space code 2) is rejected when bits 31:28 of its last byte address (address plus size minus 1) differ from bits 31:28 of its address.
- R4: Any request whose address plus size reaches or exceeds 2^32 is rejected.
- R5: An accepted request drives bus_addr with the window base plus the address, taken modulo 2^32. The bases are 0xD0010000 for port I/O, 0xE0000000 for memory and 0xF0000000 for firmware. bus_start equals 1 in the same cycle.
- R6: After an accepted firmware request, cfg_seg holds address bits 31:28 from the next clock edge on.
- R7: A firmware read is legal only for sizes 1, 2, 4, 16 and 128. These sizes are coded 0, 1, 2, 4 and 7 respectively. After an accepted firmware read, cfg_rdsz holds that code in bits 27:24 and zero in every other bit. A firmware read of any other size is rejected.
- R8: seg_wr pulses with an accepted firmware request only when the segment register is unknown or holds a different segment. rdsz_wr pulses with an accepted firmware read only when the read-size register is unknown or holds a different code. With no pulse, the register keeps its value.
- R9: A firmware write never pulses rdsz_wr and never changes cfg_rdsz.
- R10: A rejected request raises rsp_perr in the same cycle. It gives bus_start = 0, bus_addr = 0, and no register strobe or change. Requests with size 0 or space code 3 are always rejected.
- R11: While reset is asserted and just after it, cfg_seg = 0, cfg_rdsz = 0, and no response or strobe is raised without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_space | input | 2 | 0 port I/O, 1 memory, 2 firmware, 3 reserved |
| req_addr | input | 32 | Address within the space |
| req_size | input | 8 | Access size in bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| rsp_ok | output | 1 | Request accepted (same cycle) |
| rsp_perr | output | 1 | Request rejected with parameter error (same cycle) |
| bus_start | output | 1 | Internal access starts this cycle |
| bus_write | output | 1 | Direction of the started internal access |
| bus_addr | output | 32 | Translated internal address, 0 when not started |
| seg_wr | output | 1 | Segment register is rewritten at the next edge |
| rdsz_wr | output | 1 | Read-size register is rewritten at the next edge |
| cfg_seg | output | 4 | Current segment-select value |
| cfg_rdsz | output | 32 | Current read-size register, code in bits 27:24 |

## Verification
The accept/reject decision, bus_addr, bus_start and the two write strobes are combinational, so each is due in the cycle the request is driven. The bench drives a request after a falling edge and samples these outputs one time step later, before the next rising edge. The configuration registers change on the rising edge that ends the request cycle. The bench therefore reads cfg_seg and cfg_rdsz one time step after that edge and compares them with a model it keeps of its own. The model is also checked after rejected requests and firmware writes, to show that nothing moved.

// File: rtl/lpc_xlate_pkg.sv
package lpc_xlate_pkg;

  localparam int LPC_AW   = 32;
  localparam int LPC_SZW  = 8;
  localparam int LPC_SEGW = 4;
  localparam int LPC_CODW = 4;

  typedef enum logic [1:0] {
    SPC_IO  = 2'd0,
    SPC_MEM = 2'd1,
    SPC_FW  = 2'd2,
    SPC_RSV = 2'd3
  } lpc_space_e;

  typedef struct packed {
    logic                legal;
    logic [LPC_CODW-1:0] code;
  } rd_code_t;

  // End address, one bit wider than the address so a wrap is visible.
  function automatic logic [LPC_AW:0] span_end(input logic [LPC_AW-1:0] a,
                                               input logic [LPC_SZW-1:0] s);
    return {1'b0, a} + {{(LPC_AW+1-LPC_SZW){1'b0}}, s};
  endfunction

  // Segment number of the byte at the given address.
  function automatic logic [LPC_SEGW-1:0] seg_of(input logic [LPC_AW-1:0] a);
    return a[LPC_AW-1 -: LPC_SEGW];
  endfunction

  // Byte count to read-size code.
  function automatic rd_code_t size_code(input logic [LPC_SZW-1:0] s);
    rd_code_t r;
    r.legal = 1'b1;
    case (s)
      8'd1:    r.code = 4'd0;
      8'd2:    r.code = 4'd1;
      8'd4:    r.code = 4'd2;
      8'd16:   r.code = 4'd4;
      8'd128:  r.code = 4'd7;
      default: begin r.code = 4'd0; r.legal = 1'b0; end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lpc_bound_check.sv
module lpc_bound_check
  import lpc_xlate_pkg::*;
#(
  parameter logic [LPC_AW:0] IO_LIMIT  = 33'h0_0001_0000,
  parameter logic [LPC_AW:0] MEM_LIMIT = 33'h0_1000_0000
) (
  input  logic [1:0]          space,
  input  logic [LPC_AW-1:0]   addr,
  input  logic [LPC_SZW-1:0]  size,
  input  logic                write,
  output logic                legal,
  output logic                wrap_hit,
  output logic                seg_cross,
  output logic [LPC_CODW-1:0] rd_code
);

  logic [LPC_AW:0]   end_a;
  logic [LPC_AW-1:0] last_a;
  logic              size_zero;
  logic              byte_only;
  rd_code_t          rc;

  always_comb begin
    end_a     = span_end(addr, size);
    last_a    = end_a[LPC_AW-1:0] - 1'b1;
    size_zero = (size == '0);
    byte_only = (size == LPC_SZW'(1));
    wrap_hit  = end_a[LPC_AW];
    seg_cross = (seg_of(last_a) != seg_of(addr));
    rc        = size_code(size);
    rd_code   = rc.code;
  end

  always_comb begin
    legal = 1'b0;
    if (!size_zero && !wrap_hit) begin
      case (lpc_space_e'(space))
        SPC_IO:  legal = byte_only && (end_a <= IO_LIMIT);
        SPC_MEM: legal = byte_only && (end_a <= MEM_LIMIT);
        SPC_FW:  legal = !seg_cross && (write || rc.legal);
        default: legal = 1'b0;
      endcase
    end
  end

  // A size-0 request must never be legal.
  always_comb begin
    if (size_zero) assert (!legal) else $error("p_no_empty_r10");
  end

endmodule

// File: rtl/lpc_fw_cfg.sv
module lpc_fw_cfg
  import lpc_xlate_pkg::*;
#(
  parameter int RDSZ_LSB = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fw_accept,
  input  logic                fw_read,
  input  logic [LPC_SEGW-1:0] seg_in,
  input  logic [LPC_CODW-1:0] code_in,
  output logic                seg_wr,
  output logic                rdsz_wr,
  output logic [LPC_SEGW-1:0] seg_q,
  output logic [LPC_AW-1:0]   rdsz_reg
);

  logic                seg_known;
  logic                code_known;
  logic [LPC_CODW-1:0] code_q;

  assign seg_wr  = fw_accept && (!seg_known || (seg_q != seg_in));
  assign rdsz_wr = fw_accept && fw_read && (!code_known || (code_q != code_in));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q      <= '0;
      seg_known  <= 1'b0;
      code_q     <= '0;
      code_known <= 1'b0;
    end else begin
      if (seg_wr) begin
        seg_q     <= seg_in;
        seg_known <= 1'b1;
      end
      if (rdsz_wr) begin
        code_q     <= code_in;
        code_known <= 1'b1;
      end
    end
  end

  always_comb begin
    rdsz_reg = '0;
    rdsz_reg[RDSZ_LSB +: LPC_CODW] = code_q;
  end

  p_seg_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seg_wr |=> (seg_q == $past(seg_in)));

  p_seg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_wr |=> $stable(seg_q));

  p_rdsz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdsz_wr |=> $stable(rdsz_reg));

  p_rdsz_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdsz_wr |=> (rdsz_reg[RDSZ_LSB +: LPC_CODW] == $past(code_in)));

  p_no_write_rdsz_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_accept && !fw_read) |-> !rdsz_wr);

endmodule

// File: rtl/lpc_window_xlate.sv
module lpc_window_xlate
  import lpc_xlate_pkg::*;
#(
  parameter logic [LPC_AW-1:0] IO_BASE  = 32'hD001_0000,
  parameter logic [LPC_AW-1:0] MEM_BASE = 32'hE000_0000,
  parameter logic [LPC_AW-1:0] FW_BASE  = 32'hF000_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [1:0]          req_space,
  input  logic [31:0]         req_addr,
  input  logic [7:0]          req_size,
  input  logic                req_write,
  output logic                rsp_ok,
  output logic                rsp_perr,
  output logic                bus_start,
  output logic                bus_write,
  output logic [31:0]         bus_addr,
  output logic                seg_wr,
  output logic                rdsz_wr,
  output logic [3:0]          cfg_seg,
  output logic [31:0]         cfg_rdsz
);

  logic                legal;
  logic                wrap_hit;
  logic                seg_cross;
  logic [LPC_CODW-1:0] rd_code;
  logic                is_fw;
  logic                fw_accept;
  logic [LPC_AW-1:0]   win_base;

  lpc_bound_check u_chk (
    .space     (req_space),
    .addr      (req_addr),
    .size      (req_size),
    .write     (req_write),
    .legal     (legal),
    .wrap_hit  (wrap_hit),
    .seg_cross (seg_cross),
    .rd_code   (rd_code)
  );

  always_comb begin
    case (lpc_space_e'(req_space))
      SPC_IO:  win_base = IO_BASE;
      SPC_MEM: win_base = MEM_BASE;
      default: win_base = FW_BASE;
    endcase
  end

  assign is_fw     = (lpc_space_e'(req_space) == SPC_FW);
  assign rsp_ok    = req_valid && legal;
  assign rsp_perr  = req_valid && !legal;
  assign bus_start = rsp_ok;
  assign bus_write = rsp_ok && req_write;
  assign bus_addr  = rsp_ok ? (win_base + req_addr) : '0;
  assign fw_accept = rsp_ok && is_fw;

  lpc_fw_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw_accept (fw_accept),
    .fw_read   (!req_write),
    .seg_in    (seg_of(req_addr)),
    .code_in   (rd_code),
    .seg_wr    (seg_wr),
    .rdsz_wr   (rdsz_wr),
    .seg_q     (cfg_seg),
    .rdsz_reg  (cfg_rdsz)
  );

  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_perr |-> (!bus_start && !seg_wr && !rdsz_wr && (bus_addr == '0)));

  p_wrap_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && wrap_hit) |-> rsp_perr);

  p_cross_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_fw && seg_cross) |-> !bus_start);

  p_excl_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_ok, rsp_perr}));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(bus_start || seg_wr || rdsz_wr || rsp_perr));

endmodule

// File: tb/lpc_window_xlate_tb_top.sv
module lpc_window_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_space = 2'd0;
  logic [31:0] req_addr = 32'd0;
  logic [7:0]  req_size = 8'd0;
  logic        req_write = 1'b0;
  logic        rsp_ok, rsp_perr, bus_start, bus_write, seg_wr, rdsz_wr;
  logic [31:0] bus_addr, cfg_rdsz;
  logic [3:0]  cfg_seg;

  int checks = 0;
  int errors = 0;

  // bench-side model of the configuration registers
  logic [3:0]  m_seg = 4'd0;
  logic        m_seg_k = 1'b0;
  logic [3:0]  m_code = 4'd0;
  logic        m_code_k = 1'b0;

  always #5 clk = ~clk;

  lpc_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_space(req_space),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .rsp_ok(rsp_ok), .rsp_perr(rsp_perr), .bus_start(bus_start),
    .bus_write(bus_write), .bus_addr(bus_addr), .seg_wr(seg_wr),
    .rdsz_wr(rdsz_wr), .cfg_seg(cfg_seg), .cfg_rdsz(cfg_rdsz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench's own reading of the rules.
  function automatic logic [4:0] code_for(input logic [7:0] s);
    if (s == 8'd1) return 5'h10;
    if (s == 8'd2) return 5'h11;
    if (s == 8'd4) return 5'h12;
    if (s == 8'd16) return 5'h14;
    if (s == 8'd128) return 5'h17;
    return 5'h00;
  endfunction

  function automatic logic legal_ref(input logic [1:0] sp, input logic [31:0] a,
                                     input logic [7:0] s, input logic w);
    longint unsigned e;
    e = longint'(a) + longint'(s);
    if (s == 0 || e >= 64'h1_0000_0000) return 1'b0;
    if (sp == 2'd0) return (s == 1) && (e <= 64'h1_0000);
    if (sp == 2'd1) return (s == 1) && (e <= 64'h1000_0000);
    if (sp == 2'd2) begin
      if ((a >> 28) != ((e - 1) >> 28)) return 1'b0;
      return w || code_for(s)[4];
    end
    return 1'b0;
  endfunction

  task automatic do_req(input string req, input logic [1:0] sp, input logic [31:0] a,
                        input logic [7:0] s, input logic w);
    logic        ok;
    logic [31:0] base, ea;
    logic        e_sw, e_rw;
    logic [4:0]  cc;
    ok = legal_ref(sp, a, s, w);
    base = (sp == 2'd0) ? 32'hD001_0000 : (sp == 2'd1) ? 32'hE000_0000 : 32'hF000_0000;
    ea = ok ? base + a : 32'd0;
    cc = code_for(s);
    e_sw = ok && sp == 2'd2 && (!m_seg_k || m_seg != a[31:28]);
    e_rw = ok && sp == 2'd2 && !w && (!m_code_k || m_code != cc[3:0]);
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_addr = a; req_size = s; req_write = w;
    #1;
    chk({req, " ok"}, {31'd0, rsp_ok}, {31'd0, ok});
    chk({req, " perr R10"}, {31'd0, rsp_perr}, {31'd0, !ok});
    chk({req, " start"}, {31'd0, bus_start}, {31'd0, ok});
    chk({req, " addr R5"}, bus_addr, ea);
    chk({req, " seg_wr R8"}, {31'd0, seg_wr}, {31'd0, e_sw});
    chk({req, " rdsz_wr R8 R9"}, {31'd0, rdsz_wr}, {31'd0, e_rw});
    @(posedge clk);
    #1;
    if (e_sw) begin m_seg = a[31:28]; m_seg_k = 1'b1; end
    if (e_rw) begin m_code = cc[3:0]; m_code_k = 1'b1; end
    chk({req, " cfg_seg R6"}, {28'd0, cfg_seg}, {28'd0, m_seg});
    chk({req, " cfg_rdsz R7"}, cfg_rdsz, {4'd0, m_code, 24'd0});
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("reset cfg_seg R11", {28'd0, cfg_seg}, 32'd0);
    chk("reset cfg_rdsz R11", cfg_rdsz, 32'd0);
    chk("reset idle R11", {31'd0, bus_start | rsp_perr | seg_wr}, 32'd0);
  endtask

  task automatic t_io;
    do_req("io low R1 R5", 2'd0, 32'h0000_0060, 8'd1, 1'b0);
    do_req("io top R1", 2'd0, 32'h0000_FFFF, 8'd1, 1'b1);
    do_req("io over R1", 2'd0, 32'h0001_0000, 8'd1, 1'b0);
    do_req("io size2 R1", 2'd0, 32'h0000_0010, 8'd2, 1'b0);
  endtask

  task automatic t_mem;
    do_req("mem top R2 R5", 2'd1, 32'h0FFF_FFFF, 8'd1, 1'b0);
    do_req("mem over R2", 2'd1, 32'h1000_0000, 8'd1, 1'b1);
    do_req("mem size4 R2", 2'd1, 32'h0000_0100, 8'd4, 1'b0);
  endtask

  task automatic t_fw;
    do_req("fw rd first R6 R7", 2'd2, 32'h3000_0010, 8'd4, 1'b0);
    do_req("fw rd repeat R8", 2'd2, 32'h3000_0020, 8'd4, 1'b0);
    do_req("fw wr same seg R9", 2'd2, 32'h3000_0000, 8'd2, 1'b1);
    do_req("fw wr new seg R6 R9", 2'd2, 32'h5000_0000, 8'd1, 1'b1);
    do_req("fw cross R3", 2'd2, 32'h5FFF_FFFE, 8'd4, 1'b0);
    do_req("fw edge R3", 2'd2, 32'h5FFF_FFFC, 8'd4, 1'b0);
    do_req("fw rd16 R7", 2'd2, 32'h5000_0100, 8'd16, 1'b0);
    do_req("fw rd128 R7", 2'd2, 32'h5000_0200, 8'd128, 1'b0);
    do_req("fw rd2 R7", 2'd2, 32'h5000_0300, 8'd2, 1'b0);
    do_req("fw rd1 R7", 2'd2, 32'h5000_0400, 8'd1, 1'b0);
    do_req("fw rd3 bad R7", 2'd2, 32'h7000_0000, 8'd3, 1'b0);
    do_req("fw rd8 bad R7", 2'd2, 32'h7000_0000, 8'd8, 1'b0);
    do_req("fw wr3 R9", 2'd2, 32'h7000_0000, 8'd3, 1'b1);
  endtask

  task automatic t_reject;
    do_req("wrap2 R4", 2'd2, 32'hFFFF_FFFF, 8'd2, 1'b0);
    do_req("wrap exact R4", 2'd2, 32'hFFFF_FFFF, 8'd1, 1'b1);
    do_req("rsv space R10", 2'd3, 32'h0000_0000, 8'd1, 1'b0);
    do_req("size0 R10", 2'd2, 32'h1000_0000, 8'd0, 1'b1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset();
        t_io();
        t_mem();
        t_fw();
        t_reject();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule